// File: doc/BRIEF.md
# Secure Wipe Sequencer

This block overwrites three storage targets of an accelerator core with pseudo-random words: the internal state (both register files), the data memory and the instruction memory. Each sweep takes one cycle per word. It visits addresses from zero up to the depth of the target, and a free-running LFSR supplies the fill data. Two kinds of source can ask for a wipe. The host asks through a three-bit command write. The core itself asks through three inputs: a recoverable-error wipe, an end-of-program wipe and a fatal-error wipe.

The block arbitrates pending requests in a fixed order. It also reports when the work is finished, but only to the host: a wipe started by the core never raises the done interrupt. This avoids a second done at normal program end and a spurious done when the host has no operation running. While any wipe is pending or running, the error lines passed through this block are held at zero.

Top module: `wipe_sequencer`

## Requirements
- R1: After reset, busy_o is 0. No write strobe or done_o is high, and err_o equals err_raw_i.
- R2: A host command write (host_wipe_valid_i high for one cycle) marks each target whose bit is 1 in host_wipe_sel_i as pending. Bit 0 is internal state, bit 1 is data memory and bit 2 is instruction memory. Writing starts two clock edges after the write is sampled. Each target is swept from address 0 to its depth minus 1, one word per cycle, with only its own strobe high.
- R3: Pending targets are served in the order internal state, then data memory, then instruction memory. One idle cycle separates two sweeps.
- R4: done_o pulses for exactly one cycle, in the cycle after the final write of the last host-requested target. It pulses once per group of host requests.
- R5: Wipes requested by err_wipe_i, prog_end_i or fatal_i never cause done_o.
- R6: A pulse on fatal_i requests both the data-memory and the instruction-memory wipes.
- R7: err_o is 0 whenever busy_o is 1, and equals err_raw_i when busy_o is 0.
- R8: stack_clr_o is high for one cycle, together with the first internal-state write at address 0, so that the stack pointers reset.
- R9: A host write that arrives while a sweep runs is held as pending and served after that sweep. This also applies when it names the target being swept.
- R10: wdata_o is never zero and changes on every write cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| host_wipe_valid_i | input | 1 | Host command write strobe |
| host_wipe_sel_i | input | 3 | Target select bits: 0 internal, 1 data memory, 2 instruction memory |
| err_wipe_i | input | 1 | Internal-state wipe request from the error controller |
| prog_end_i | input | 1 | Internal-state wipe request at normal program end |
| fatal_i | input | 1 | Fatal error: wipe both memories |
| err_raw_i | input | ERR_W | Error indications before suppression |
| err_o | output | ERR_W | Error indications, zero while wiping |
| int_we_o | output | 1 | Internal-state write strobe |
| int_addr_o | output | $clog2(INT_DEPTH) | Internal-state word address |
| dmem_we_o | output | 1 | Data-memory write strobe |
| dmem_addr_o | output | $clog2(DMEM_DEPTH) | Data-memory word address |
| imem_we_o | output | 1 | Instruction-memory write strobe |
| imem_addr_o | output | $clog2(IMEM_DEPTH) | Instruction-memory word address |
| wdata_o | output | DATA_W | Fill word for the active strobe |
| stack_clr_o | output | 1 | Loop and call stack pointer reset pulse |
| busy_o | output | 1 | A wipe is pending or running |
| done_o | output | 1 | Done interrupt request pulse |

## Verification
Two functions can fall into the same cycle. The first is a core-initiated fatal wipe, sampled in the same cycle as a host request for the internal state. The bench raises fatal_i and the host write together and expects the internal sweep first. It then expects done_o in the gap before the data-memory sweep and no further done after the silent memory sweeps. The second collision is an error arriving in the cycle right after a host write, when the request is only pending and no strobe is active yet. The bench then requires err_o to be zero already, and requires the same raw error to pass through once the block is idle again.

// File: rtl/wipe_pkg.sv
package wipe_pkg;

    localparam int unsigned NTGT = 3;

    typedef enum logic [1:0] {
        TGT_INT  = 2'd0,
        TGT_DMEM = 2'd1,
        TGT_IMEM = 2'd2
    } tgt_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } st_e;

endpackage

// File: rtl/wipe_arbiter.sv
module wipe_arbiter #(
    parameter int unsigned N  = 3,
    localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req_i,
    output logic [IW-1:0] idx_o,
    output logic          any_o
);

    // Fixed priority: the lowest index wins.
    always_comb begin
        idx_o = '0;
        any_o = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req_i[i]) begin
                idx_o = IW'(i);
                any_o = 1'b1;
            end
        end
    end

endmodule

// File: rtl/wipe_lfsr.sv
module wipe_lfsr #(
    parameter int unsigned        W    = 32,
    parameter logic [W-1:0]       TAPS = 32'h8020_0003,
    parameter logic [W-1:0]       SEED = 32'h1234_5679
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         step_i,
    output logic [W-1:0] value_o
);

    logic [W-1:0] lfsr_d, lfsr_q;

    always_comb begin
        lfsr_d = lfsr_q;
        if (step_i) begin
            lfsr_d = lfsr_q[0] ? ((lfsr_q >> 1) ^ TAPS) : (lfsr_q >> 1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) lfsr_q <= SEED;
        else         lfsr_q <= lfsr_d;
    end

    assign value_o = lfsr_q;

    AST_LFSR_LIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        lfsr_q != '0) else $error("lfsr stuck at zero"); // R10

endmodule

// File: rtl/wipe_sequencer.sv
module wipe_sequencer
    import wipe_pkg::*;
#(
    parameter int unsigned DATA_W     = 32,
    parameter int unsigned INT_DEPTH  = 8,
    parameter int unsigned DMEM_DEPTH = 16,
    parameter int unsigned IMEM_DEPTH = 32,
    parameter int unsigned ERR_W      = 4,
    localparam int unsigned IAW = $clog2(INT_DEPTH),
    localparam int unsigned DAW = $clog2(DMEM_DEPTH),
    localparam int unsigned MAW = $clog2(IMEM_DEPTH)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              host_wipe_valid_i,
    input  logic [2:0]        host_wipe_sel_i,
    input  logic              err_wipe_i,
    input  logic              prog_end_i,
    input  logic              fatal_i,
    input  logic [ERR_W-1:0]  err_raw_i,
    output logic [ERR_W-1:0]  err_o,
    output logic              int_we_o,
    output logic [IAW-1:0]    int_addr_o,
    output logic              dmem_we_o,
    output logic [DAW-1:0]    dmem_addr_o,
    output logic              imem_we_o,
    output logic [MAW-1:0]    imem_addr_o,
    output logic [DATA_W-1:0] wdata_o,
    output logic              stack_clr_o,
    output logic              busy_o,
    output logic              done_o
);

    localparam int unsigned MEM_MAX   = (DMEM_DEPTH > IMEM_DEPTH) ? DMEM_DEPTH : IMEM_DEPTH;
    localparam int unsigned MAX_DEPTH = (INT_DEPTH > MEM_MAX) ? INT_DEPTH : MEM_MAX;
    localparam int unsigned AW        = $clog2(MAX_DEPTH);
    localparam int unsigned SW        = $clog2(NTGT);
    localparam logic [AW-1:0] INT_LAST  = AW'(INT_DEPTH - 1);
    localparam logic [AW-1:0] DMEM_LAST = AW'(DMEM_DEPTH - 1);
    localparam logic [AW-1:0] IMEM_LAST = AW'(IMEM_DEPTH - 1);

    typedef struct packed {
        st_e             st;
        tgt_e            cur;
        logic [AW-1:0]   addr;
        logic [NTGT-1:0] pend;
        logic [NTGT-1:0] host;
        logic            cur_host;
        logic            host_seen;
        logic            done;
        logic            clr;
    } seq_t;

    seq_t            seq_d, seq_q;
    logic [SW-1:0]   arb_idx;
    logic            arb_any;
    logic [AW-1:0]   last_addr;
    logic [NTGT-1:0] new_host, new_int;
    logic            seen;
    logic            run;

    wipe_arbiter #(.N(NTGT)) u_arb (
        .req_i (seq_q.pend),
        .idx_o (arb_idx),
        .any_o (arb_any)
    );

    wipe_lfsr #(.W(DATA_W)) u_lfsr (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .step_i  (run),
        .value_o (wdata_o)
    );

    always_comb begin
        case (seq_q.cur)
            TGT_INT:  last_addr = INT_LAST;
            TGT_DMEM: last_addr = DMEM_LAST;
            default:  last_addr = IMEM_LAST;
        endcase
    end

    always_comb begin
        seq_d      = seq_q;
        seq_d.done = 1'b0;
        seq_d.clr  = 1'b0;
        new_host   = host_wipe_valid_i ? host_wipe_sel_i : '0;
        new_int    = {fatal_i, fatal_i, err_wipe_i | prog_end_i};
        seen       = seq_q.host_seen | seq_q.cur_host;

        case (seq_q.st)
            ST_IDLE: begin
                if (arb_any) begin
                    seq_d.st             = ST_RUN;
                    seq_d.cur            = tgt_e'(arb_idx);
                    seq_d.addr           = '0;
                    seq_d.cur_host       = seq_q.host[arb_idx];
                    seq_d.pend[arb_idx]  = 1'b0;
                    seq_d.host[arb_idx]  = 1'b0;
                    seq_d.clr            = (tgt_e'(arb_idx) == TGT_INT);
                end
            end
            default: begin
                if (seq_q.addr == last_addr) begin
                    seq_d.st       = ST_IDLE;
                    seq_d.cur_host = 1'b0;
                    if (seen && !(|(seq_q.host | new_host))) begin
                        seq_d.done      = 1'b1;
                        seq_d.host_seen = 1'b0;
                    end else begin
                        seq_d.host_seen = seen;
                    end
                end else begin
                    seq_d.addr = seq_q.addr + 1'b1;
                end
            end
        endcase

        seq_d.pend = seq_d.pend | new_host | new_int;
        seq_d.host = seq_d.host | new_host;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) seq_q <= seq_t'('0);
        else         seq_q <= seq_d;
    end

    assign run         = (seq_q.st == ST_RUN);
    assign int_we_o    = run && (seq_q.cur == TGT_INT);
    assign dmem_we_o   = run && (seq_q.cur == TGT_DMEM);
    assign imem_we_o   = run && (seq_q.cur == TGT_IMEM);
    assign int_addr_o  = seq_q.addr[IAW-1:0];
    assign dmem_addr_o = seq_q.addr[DAW-1:0];
    assign imem_addr_o = seq_q.addr[MAW-1:0];
    assign stack_clr_o = seq_q.clr;
    assign done_o      = seq_q.done;
    assign busy_o      = run || (|seq_q.pend);
    assign err_o       = busy_o ? '0 : err_raw_i;

    AST_ONE_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0({int_we_o, dmem_we_o, imem_we_o})) else $error("two strobes"); // R2
    AST_ADDR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (run && $past(run) && $past(rst_ni)) |-> (seq_q.addr == $past(seq_q.addr) + 1'b1))
        else $error("address skipped"); // R2
    AST_DONE_AFTER_SWEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> ($past(run) && !run)) else $error("done without sweep end"); // R4
    AST_DONE_HOST_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> $past(seq_q.host_seen | seq_q.cur_host)) else $error("silent wipe raised done"); // R5
    AST_FATAL_PENDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fatal_i |=> (seq_q.pend[TGT_DMEM] && seq_q.pend[TGT_IMEM])) else $error("fatal lost"); // R6
    AST_STACK_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
        stack_clr_o |-> (int_we_o && int_addr_o == '0)) else $error("stack clear misplaced"); // R8

endmodule

// File: tb/test_wipe_sequencer.sv
module test_wipe_sequencer;

    localparam int INT_D  = 8;
    localparam int DMEM_D = 16;
    localparam int IMEM_D = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_valid = 1'b0;
    logic [2:0]  host_sel = '0;
    logic        err_wipe = 1'b0;
    logic        prog_end = 1'b0;
    logic        fatal = 1'b0;
    logic [3:0]  err_raw = '0;
    logic [3:0]  err_o;
    logic        int_we, dmem_we, imem_we;
    logic [2:0]  int_addr;
    logic [3:0]  dmem_addr;
    logic [4:0]  imem_addr;
    logic [31:0] wdata;
    logic        stack_clr, busy, done;

    always #4 clk = ~clk;

    wipe_sequencer i_wipe_sequencer (
        .clk_i(clk), .rst_ni(rst_n),
        .host_wipe_valid_i(host_valid), .host_wipe_sel_i(host_sel),
        .err_wipe_i(err_wipe), .prog_end_i(prog_end), .fatal_i(fatal),
        .err_raw_i(err_raw), .err_o(err_o),
        .int_we_o(int_we), .int_addr_o(int_addr),
        .dmem_we_o(dmem_we), .dmem_addr_o(dmem_addr),
        .imem_we_o(imem_we), .imem_addr_o(imem_addr),
        .wdata_o(wdata), .stack_clr_o(stack_clr),
        .busy_o(busy), .done_o(done)
    );

    typedef struct {
        int    kind;   // 0 write, 1 done
        int    tgt;
        int    addr;
        string req;
    } exp_t;

    exp_t exp_q[$];
    int   n_chk = 0;
    int   n_bad = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
        end
    endtask

    task automatic push_sweep(input int tgt, input string req);
        int depth;
        depth = (tgt == 0) ? INT_D : ((tgt == 1) ? DMEM_D : IMEM_D);
        for (int a = 0; a < depth; a++) begin
            exp_t e;
            e.kind = 0; e.tgt = tgt; e.addr = a; e.req = req;
            exp_q.push_back(e);
        end
    endtask

    task automatic push_done(input string req);
        exp_t e;
        e.kind = 1; e.tgt = 0; e.addr = 0; e.req = req;
        exp_q.push_back(e);
    endtask

    task automatic host_write(input logic [2:0] m);
        @(negedge clk);
        host_valid = 1'b1;
        host_sel   = m;
        @(negedge clk);
        host_valid = 1'b0;
        host_sel   = '0;
    endtask

    task automatic drain(input string req);
        int t = 0;
        while ((exp_q.size() != 0 || busy) && t < 2000) begin
            @(negedge clk);
            t++;
        end
        repeat (4) @(negedge clk);
        chk(exp_q.size() == 0, req, "items left", exp_q.size(), 0);
    endtask

    // Monitor: compares every strobe or done cycle against the scoreboard.
    logic [31:0] prev_wdata;
    bit          prev_we = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            int nwe;
            nwe = int'(int_we) + int'(dmem_we) + int'(imem_we);
            if (nwe > 0 || done) begin
                int otgt, oaddr, okind;
                okind = done ? 1 : 0;
                otgt  = dmem_we ? 1 : (imem_we ? 2 : 0);
                oaddr = dmem_we ? int'(dmem_addr) : (imem_we ? int'(imem_addr) : int'(int_addr));
                chk(nwe <= 1 && !(nwe == 1 && done), "R2", "strobes at once", nwe, 1);
                if (exp_q.size() == 0) begin
                    chk(1'b0, okind ? "R5" : "R2", "unexpected event kind", okind, -1);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    chk(okind == e.kind, e.req, "event kind", okind, e.kind);
                    if (e.kind == 0 && okind == 0) begin
                        chk(otgt == e.tgt, e.req, "target", otgt, e.tgt);
                        chk(oaddr == e.addr, e.req, "address", oaddr, e.addr);
                    end
                end
                if (nwe > 0) begin
                    chk(stack_clr == (int_we && int_addr == 0), "R8", "stack clear",
                        int'(stack_clr), int'(int_we && int_addr == 0));
                    chk(wdata != 0, "R10", "fill zero", int'(wdata != 0), 1);
                    if (prev_we)
                        chk(wdata != prev_wdata, "R10", "fill repeated", int'(wdata != prev_wdata), 1);
                end
            end else begin
                chk(!stack_clr, "R8", "stray stack clear", int'(stack_clr), 0);
            end
            prev_we    <= (nwe > 0);
            prev_wdata <= wdata;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        err_raw = 4'b0110;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        chk(!busy, "R1", "busy after reset", int'(busy), 0);
        chk(!done && !int_we && !dmem_we && !imem_we, "R1", "activity after reset", 1, 0);
        chk(err_o == err_raw, "R1", "err pass", int'(err_o), int'(err_raw));
        err_raw = '0;

        // R2: single host data-memory wipe
        push_sweep(1, "R2");
        push_done("R4");
        host_write(3'b010);
        drain("R2");

        // R3: all three targets in fixed order, one done
        push_sweep(0, "R3");
        push_sweep(1, "R3");
        push_sweep(2, "R3");
        push_done("R4");
        host_write(3'b111);
        drain("R3");

        // R5: program end wipe is silent
        push_sweep(0, "R5");
        @(negedge clk); prog_end = 1'b1;
        @(negedge clk); prog_end = 1'b0;
        drain("R5");

        // R5: error-controller wipe is silent
        push_sweep(0, "R5");
        @(negedge clk); err_wipe = 1'b1;
        @(negedge clk); err_wipe = 1'b0;
        drain("R5");

        // R6: fatal wipes both memories silently
        push_sweep(1, "R6");
        push_sweep(2, "R6");
        @(negedge clk); fatal = 1'b1;
        @(negedge clk); fatal = 1'b0;
        drain("R6");

        // R4/R5: fatal and host internal request in the same cycle
        push_sweep(0, "R4");
        push_done("R4");
        push_sweep(1, "R6");
        push_sweep(2, "R6");
        @(negedge clk); fatal = 1'b1; host_valid = 1'b1; host_sel = 3'b001;
        @(negedge clk); fatal = 1'b0; host_valid = 1'b0; host_sel = '0;
        drain("R4");

        // R9 and R7: request during a sweep, errors while busy
        err_raw = 4'b1011;
        push_sweep(1, "R9");
        push_sweep(0, "R9");
        push_done("R9");
        host_write(3'b010);
        #1;
        chk(busy, "R7", "busy while pending", int'(busy), 1);
        chk(err_o == 0, "R7", "err while pending", int'(err_o), 0);
        repeat (5) @(negedge clk);
        host_write(3'b001);
        #1;
        chk(err_o == 0, "R7", "err while sweeping", int'(err_o), 0);
        drain("R9");
        #1;
        chk(err_o == err_raw, "R7", "err when idle", int'(err_o), int'(err_raw));
        err_raw = '0;

        // R9: re-request of the target being swept
        push_sweep(0, "R9");
        push_sweep(0, "R9");
        push_done("R9");
        host_write(3'b001);
        repeat (3) @(negedge clk);
        host_write(3'b001);
        drain("R9");

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule